// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block takes a fast oscillator and derives from it everything a processor's bus timing needs. It produces a processor clock at one third of the oscillator rate that is high for one oscillator period in three, and a peripheral clock at half the processor clock rate with an even duty cycle. It also repeats the raw oscillator on a separate output for other devices.

It turns an active-low external reset request into a clean active-high reset. That reset only moves at the end of a processor clock high phase. The block merges two ready sources, each gated by its own active-low enable, into one ready output. The processor uses that output to stretch a bus cycle with wait states, and the output only changes when a processor clock cycle begins.

All logic is synchronous to the oscillator. The derived clocks are registered outputs. Two single-cycle strobes mark the oscillator cycle that ends in each processor clock rising and falling edge, so downstream logic can stay in the oscillator domain. A separate asynchronous active-low power-on reset initialises the block itself.

Top module: `clkdiv3_gen`

## Requirements
- R1: `cpu_clk_o` repeats every 3 oscillator cycles and is high for exactly 1 of them.
- R2: `per_clk_o` toggles only at a rise of `cpu_clk_o`, so its period is 6 oscillator cycles with 3 high and 3 low.
- R3: `osc_o` equals `osc_i` at all times.
- R4: On the first oscillator rising edge after `por_n_i` goes high, `cpu_clk_o` and `per_clk_o` both go high together.
- R5: `reset_o` is high while `res_n_i` is low. It follows a change of `res_n_i` no sooner than 2 oscillator edges later, through a two-flop synchroniser. It changes only on an oscillator edge at which `cpu_clk_o` falls.
- R6: `ready_o` settles to (`rdy_a_i` AND NOT `aen_a_n_i`) OR (`rdy_b_i` AND NOT `aen_b_n_i`). Both enables are active low.
- R7: `ready_o` changes only on an oscillator edge at which `cpu_clk_o` rises. It passes through two registers, so it is unchanged 1 edge after its inputs move.
- R8: `rise_en_o` is high for exactly the oscillator cycle that ends with a rise of `cpu_clk_o`. `fall_en_o` is high for exactly the cycle that ends with a fall of `cpu_clk_o`. Neither strobe fires before the first rise after power-on reset.
- R9: While `por_n_i` is low, `cpu_clk_o`, `per_clk_o`, `ready_o`, `rise_en_o` and `fall_en_o` are 0 and `reset_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_i | input | 1 | Oscillator input; clocks every register |
| por_n_i | input | 1 | Asynchronous active-low power-on reset of the block |
| res_n_i | input | 1 | Active-low external reset request |
| rdy_a_i | input | 1 | First ready source |
| aen_a_n_i | input | 1 | Active-low enable qualifying the first ready source |
| rdy_b_i | input | 1 | Second ready source |
| aen_b_n_i | input | 1 | Active-low enable qualifying the second ready source |
| osc_o | output | 1 | Copy of the oscillator |
| cpu_clk_o | output | 1 | Processor clock, oscillator / 3, 33% high |
| per_clk_o | output | 1 | Peripheral clock, oscillator / 6, 50% high |
| reset_o | output | 1 | Active-high conditioned reset |
| ready_o | output | 1 | Merged ready; low requests wait states |
| rise_en_o | output | 1 | Strobe for the cycle ending in a processor clock rise |
| fall_en_o | output | 1 | Strobe for the cycle ending in a processor clock fall |

## Verification
The derived clocks and strobes are due on the first oscillator edge after power-on release. The bench compares them to a phase computed from the edge count, sampling at each falling oscillator edge. A change on the reset request is still invisible one edge later, because of the two synchroniser flops. It must then appear within five edges, and the bench checks that the edge on which it appears is one where the processor clock fell. Ready is checked as unchanged one edge after a new input pattern and as settled six edges later, which bounds the worst case of two registers plus waiting for a processor clock rise.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
   localparam int CG_DIV_DEF   = 3;
   localparam int CG_HIGH_DEF  = 1;
   localparam int CG_SYNC_DEF  = 2;
   localparam int CG_RDY_DEF   = 1;
   localparam int CG_NSRC_DEF  = 2;

   typedef struct packed {
      logic rise;
      logic fall;
   } cg_edge_t;
endpackage

// File: rtl/cg_phase_div.sv
`timescale 1ns/1ps
module cg_phase_div
   import cg_pkg::*;
#(
   parameter int DIV  = CG_DIV_DEF,
   parameter int HIGH = CG_HIGH_DEF
) (
   input  logic     osc_i,
   input  logic     por_n_i,
   output logic     clk_o,
   output logic     pclk_o,
   output cg_edge_t edge_o
);
   localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
   localparam logic [PW-1:0] PH_HEND = PW'(HIGH - 1);

   if (DIV < 2) begin : g_bad_div
      $error("cg_phase_div: DIV must be at least 2");
   end
   if (HIGH < 1 || HIGH >= DIV) begin : g_bad_high
      $error("cg_phase_div: HIGH must lie in 1..DIV-1");
   end

   logic [PW-1:0] ph_q, ph_nx;
   logic          clk_q, pclk_q;
   cg_edge_t      edge_q;

   always_comb begin
      if (ph_q == PH_LAST) ph_nx = '0;
      else                 ph_nx = ph_q + 1'b1;
   end

   always_ff @(posedge osc_i or negedge por_n_i) begin
      if (!por_n_i) begin
         ph_q        <= PH_LAST;
         clk_q       <= 1'b0;
         pclk_q      <= 1'b0;
         edge_q.rise <= 1'b0;
         edge_q.fall <= 1'b0;
      end else begin
         ph_q        <= ph_nx;
         clk_q       <= (ph_nx < PW'(HIGH));
         if (ph_nx == '0) pclk_q <= ~pclk_q;
         edge_q.rise <= (ph_nx == PH_LAST);
         edge_q.fall <= (ph_nx == PH_HEND);
      end
   end

   assign clk_o  = clk_q;
   assign pclk_o = pclk_q;
   assign edge_o = edge_q;
endmodule

// File: rtl/cg_sync_chain.sv
`timescale 1ns/1ps
module cg_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic osc_i,
   input  logic por_n_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("cg_sync_chain: STAGES must be at least 1");
   end

   logic [STAGES-1:0] stg_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge osc_i or negedge por_n_i) begin
         if (!por_n_i) stg_q[i] <= RST_VAL;
         else if (i == 0) stg_q[i] <= d_i;
         else stg_q[i] <= stg_q[(i > 0) ? i - 1 : 0];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cg_ready_merge.sv
`timescale 1ns/1ps
module cg_ready_merge
   import cg_pkg::*;
#(
   parameter int NSRC   = CG_NSRC_DEF,
   parameter int STAGES = CG_RDY_DEF
) (
   input  logic            osc_i,
   input  logic            por_n_i,
   input  logic [NSRC-1:0] rdy_i,
   input  logic [NSRC-1:0] aen_n_i,
   input  logic            load_i,
   output logic            ready_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("cg_ready_merge: NSRC must be at least 1");
   end

   logic [NSRC-1:0] qual;
   logic            any_rdy, rdy_sync, ready_q;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign qual[s] = rdy_i[s] & ~aen_n_i[s];
   end
   assign any_rdy = |qual;

   cg_sync_chain #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
      .osc_i   (osc_i),
      .por_n_i (por_n_i),
      .d_i     (any_rdy),
      .q_o     (rdy_sync)
   );

   always_ff @(posedge osc_i or negedge por_n_i) begin
      if (!por_n_i)    ready_q <= 1'b0;
      else if (load_i) ready_q <= rdy_sync;
   end

   assign ready_o = ready_q;
endmodule

// File: rtl/clkdiv3_gen.sv
`timescale 1ns/1ps
module clkdiv3_gen
   import cg_pkg::*;
#(
   parameter int DIV        = CG_DIV_DEF,
   parameter int HIGH       = CG_HIGH_DEF,
   parameter int RES_STAGES = CG_SYNC_DEF,
   parameter int RDY_STAGES = CG_RDY_DEF
) (
   input  logic osc_i,
   input  logic por_n_i,
   input  logic res_n_i,
   input  logic rdy_a_i,
   input  logic aen_a_n_i,
   input  logic rdy_b_i,
   input  logic aen_b_n_i,
   output logic osc_o,
   output logic cpu_clk_o,
   output logic per_clk_o,
   output logic reset_o,
   output logic ready_o,
   output logic rise_en_o,
   output logic fall_en_o
);
   cg_edge_t edg;
   logic     res_sync, reset_q;

   assign osc_o = osc_i;

   cg_phase_div #(.DIV(DIV), .HIGH(HIGH)) u_div (
      .osc_i   (osc_i),
      .por_n_i (por_n_i),
      .clk_o   (cpu_clk_o),
      .pclk_o  (per_clk_o),
      .edge_o  (edg)
   );

   cg_sync_chain #(.STAGES(RES_STAGES), .RST_VAL(1'b0)) u_res_sync (
      .osc_i   (osc_i),
      .por_n_i (por_n_i),
      .d_i     (res_n_i),
      .q_o     (res_sync)
   );

   always_ff @(posedge osc_i or negedge por_n_i) begin
      if (!por_n_i)      reset_q <= 1'b1;
      else if (edg.fall) reset_q <= ~res_sync;
   end
   assign reset_o = reset_q;

   cg_ready_merge #(.NSRC(2), .STAGES(RDY_STAGES)) u_rdy (
      .osc_i   (osc_i),
      .por_n_i (por_n_i),
      .rdy_i   ({rdy_b_i, rdy_a_i}),
      .aen_n_i ({aen_b_n_i, aen_a_n_i}),
      .load_i  (edg.rise),
      .ready_o (ready_o)
   );

   assign rise_en_o = edg.rise;
   assign fall_en_o = edg.fall;
endmodule

// File: rtl/clkdiv3_gen_chk.sv
`timescale 1ns/1ps
module clkdiv3_gen_chk #(
   parameter int DIV  = 3,
   parameter int HIGH = 1
) (
   input logic osc_i,
   input logic por_n_i,
   input logic cpu_clk_o,
   input logic per_clk_o,
   input logic reset_o,
   input logic ready_o,
   input logic rise_en_o,
   input logic fall_en_o
);
   logic [7:0] hi_run, lo_run;

   always_ff @(posedge osc_i or negedge por_n_i) begin
      if (!por_n_i) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= cpu_clk_o ? ((hi_run == 8'hFF) ? hi_run : hi_run + 1'b1) : '0;
         lo_run <= cpu_clk_o ? '0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 1'b1);
      end
   end

   AST_CLK_HIGH_LEN: assert property (@(posedge osc_i) disable iff (!por_n_i)
      cpu_clk_o |-> (hi_run < 8'(HIGH))); // R1
   AST_CLK_LOW_LEN: assert property (@(posedge osc_i) disable iff (!por_n_i)
      !cpu_clk_o |-> (lo_run < 8'(DIV - HIGH + 1))); // R1
   AST_PCLK_ON_RISE: assert property (@(posedge osc_i) disable iff (!por_n_i)
      $changed(per_clk_o) |-> $rose(cpu_clk_o)); // R2
   AST_RESET_AT_FALL: assert property (@(posedge osc_i) disable iff (!por_n_i)
      $changed(reset_o) |-> $fell(cpu_clk_o)); // R5
   AST_READY_AT_RISE: assert property (@(posedge osc_i) disable iff (!por_n_i)
      $changed(ready_o) |-> $rose(cpu_clk_o)); // R7
   AST_RISE_STROBE: assert property (@(posedge osc_i) disable iff (!por_n_i)
      rise_en_o |=> $rose(cpu_clk_o)); // R8
   AST_FALL_STROBE: assert property (@(posedge osc_i) disable iff (!por_n_i)
      fall_en_o |=> $fell(cpu_clk_o)); // R8
endmodule

bind clkdiv3_gen clkdiv3_gen_chk #(.DIV(DIV), .HIGH(HIGH)) u_chk (
   .osc_i     (osc_i),
   .por_n_i   (por_n_i),
   .cpu_clk_o (cpu_clk_o),
   .per_clk_o (per_clk_o),
   .reset_o   (reset_o),
   .ready_o   (ready_o),
   .rise_en_o (rise_en_o),
   .fall_en_o (fall_en_o)
);

// File: tb/clkdiv3_gen_tb.sv
`timescale 1ns/1ps
module clkdiv3_gen_tb;
   logic osc = 1'b0;
   logic por_n, res_n, rdy_a, aen_a_n, rdy_b, aen_b_n;
   logic osc_o, cpu_clk, per_clk, reset_o, ready_o, rise_en, fall_en;
   int   n_run = 0;
   int   n_fail = 0;

   always #2.5 osc = ~osc;

   clkdiv3_gen u_dut (
      .osc_i     (osc),
      .por_n_i   (por_n),
      .res_n_i   (res_n),
      .rdy_a_i   (rdy_a),
      .aen_a_n_i (aen_a_n),
      .rdy_b_i   (rdy_b),
      .aen_b_n_i (aen_b_n),
      .osc_o     (osc_o),
      .cpu_clk_o (cpu_clk),
      .per_clk_o (per_clk),
      .reset_o   (reset_o),
      .ready_o   (ready_o),
      .rise_en_o (rise_en),
      .fall_en_o (fall_en)
   );

   // {rdy_a, aen_a_n, rdy_b, aen_b_n, expected ready}
   localparam logic [4:0] VEC [8] = '{
      5'b0000_0, 5'b1000_1, 5'b1100_0, 5'b0010_1,
      5'b0011_0, 5'b1111_0, 5'b1010_1, 5'b0110_1
   };

   task automatic check(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(5ns * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic prev_clk;
      logic prev_rdy;
      logic seen;
      por_n = 1'b0; res_n = 1'b0;
      rdy_a = 1'b0; aen_a_n = 1'b1; rdy_b = 1'b0; aen_b_n = 1'b1;
      repeat (3) @(negedge osc);
      check("R9 cpu_clk in reset", cpu_clk, 1'b0);
      check("R9 per_clk in reset", per_clk, 1'b0);
      check("R9 reset_o in reset", reset_o, 1'b1);
      check("R9 ready in reset", ready_o, 1'b0);
      check("R9 rise_en in reset", rise_en, 1'b0);
      check("R9 fall_en in reset", fall_en, 1'b0);
      check("R3 osc_o low", osc_o, 1'b0);
      @(posedge osc); #1;
      check("R3 osc_o high", osc_o, 1'b1);

      // Waveform after power-on release
      @(negedge osc); por_n = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         @(negedge osc);
         if (k == 1) begin
            check("R4 cpu_clk first edge", cpu_clk, 1'b1);
            check("R4 per_clk first edge", per_clk, 1'b1);
         end
         check("R1 cpu_clk phase", cpu_clk, (k % 3) == 1);
         check("R2 per_clk phase", per_clk, (((k - 1) / 3) % 2) == 0);
         check("R8 rise_en phase", rise_en, (k % 3) == 0);
         check("R8 fall_en phase", fall_en, (k % 3) == 1);
         check("R5 reset held by request", reset_o, 1'b1);
      end

      // Reset request released
      res_n = 1'b1;
      prev_clk = cpu_clk;
      @(negedge osc);
      check("R5 reset latency", reset_o, 1'b1);
      prev_clk = cpu_clk;
      seen = 1'b0;
      for (int k = 0; k < 10 && !seen; k++) begin
         @(negedge osc);
         if (reset_o == 1'b0) begin
            seen = 1'b1;
            check("R5 release on clk fall (now low)", cpu_clk, 1'b0);
            check("R5 release on clk fall (was high)", prev_clk, 1'b1);
         end
         prev_clk = cpu_clk;
      end
      check("R5 reset released", reset_o, 1'b0);

      // Reset request asserted again
      res_n = 1'b0;
      @(negedge osc);
      check("R5 assert latency", reset_o, 1'b0);
      prev_clk = cpu_clk;
      seen = 1'b0;
      for (int k = 0; k < 10 && !seen; k++) begin
         @(negedge osc);
         if (reset_o == 1'b1) begin
            seen = 1'b1;
            check("R5 assert on clk fall (now low)", cpu_clk, 1'b0);
            check("R5 assert on clk fall (was high)", prev_clk, 1'b1);
         end
         prev_clk = cpu_clk;
      end
      check("R5 reset asserted", reset_o, 1'b1);

      // Ready table
      prev_rdy = 1'b0;
      for (int i = 0; i < 8; i++) begin
         {rdy_a, aen_a_n, rdy_b, aen_b_n} = VEC[i][4:1];
         @(negedge osc);
         check("R7 ready not yet updated", ready_o, prev_rdy);
         repeat (6) @(negedge osc);
         check("R6 ready merge", ready_o, VEC[i][0]);
         prev_rdy = VEC[i][0];
      end

      // Ready change lands on a clk rise
      rdy_a = 1'b0; aen_a_n = 1'b1; rdy_b = 1'b0; aen_b_n = 1'b1;
      prev_clk = cpu_clk;
      seen = 1'b0;
      for (int k = 0; k < 10 && !seen; k++) begin
         @(negedge osc);
         if (ready_o == 1'b0) begin
            seen = 1'b1;
            check("R7 ready drop on clk rise (now high)", cpu_clk, 1'b1);
            check("R7 ready drop on clk rise (was low)", prev_clk, 1'b0);
         end
         prev_clk = cpu_clk;
      end
      check("R7 ready dropped", ready_o, 1'b0);

      // Power-on reset mid-run
      @(negedge osc); por_n = 1'b0;
      #1;
      check("R9 cpu_clk after por", cpu_clk, 1'b0);
      check("R9 reset_o after por", reset_o, 1'b1);
      @(negedge osc); por_n = 1'b1;
      @(negedge osc);
      check("R4 cpu_clk restart", cpu_clk, 1'b1);
      check("R4 per_clk restart", per_clk, 1'b1);

      finish_run();
   end
endmodule